// File: doc/BRIEF.md
# Configuration Port Access Controller

This block connects a 32-bit host register bus to the word stream of an on-chip configuration engine. The host loads configuration words into a write FIFO through one register address. It then sets a start bit in a control register, and the controller drains the FIFO onto a valid/ready output stream. The start bit reads back as set until the FIFO is empty, and then clears itself.

For readback, the host programs a word count and sets a second start bit. The controller then raises a request level towards the engine and accepts that many words from a valid-only input stream into a read FIFO. The host pops the words one at a time through the read FIFO address. Registers report free write-FIFO space and read-FIFO occupancy. A status register carries a done flag and a sticky end-of-startup flag, which is set by the first completed flush. Interrupt enable registers are plain storage. A push into a full write FIFO is dropped and latches an overflow flag.

Top module: `cfg_access_ctrl`

## Requirements
- R1: After reset, status (0x110) reads exactly 0x1, vacancy (0x114) reads the write FIFO depth (16), occupancy (0x118) reads 0, and interrupt status (0x20) reads 0.
- R2: Each host write to 0x100 stores one word and lowers vacancy by one.
- R3: A write to 0x100 while vacancy is 0 is dropped and sets interrupt status bit 0. The bit stays set until the host writes 1 to bit 0 of 0x20.
- R4: Writing 1 to control (0x10C) bit 0 sends the stored words out in push order, one per cycle where output valid and ready are both high. During the flush, control bit 0 reads 1 and status bit 0 reads 0. Both return to idle values once the FIFO is empty.
- R5: Once a flush has completed, status bit 2 (end-of-startup) reads 1 and stays set, so status reads 0x5 when idle.
- R6: Writing 1 to control bit 1 with a nonzero read size (0x108) holds the readback request high until that many input words have been accepted, each stored in the read FIFO. Occupancy then equals the size.
- R7: A read of 0x104 returns the oldest stored word and removes it, lowering occupancy by one. A read of 0x104 with an empty read FIFO returns 0.
- R8: Input stream words offered while no readback is in progress are ignored, and occupancy is unchanged.
- R9: Control writes are ignored while a flush or readback is in progress. A control write with bits 0 and 1 both set starts only the flush.
- R10: Global interrupt enable (0x1C, bit 0) and interrupt enable (0x28, bits 3:0) read back what was written. Unmapped addresses read 0.
- R11: A readback started with read size 0 completes at once, without raising the request.
- R12: Readback words that arrive while the read FIFO (depth 8) is full are dropped but still counted towards the read size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host register write strobe |
| regRdEn | input | 1 | Host register read strobe |
| regAddr | input | 13 | Host byte address |
| regWrData | input | 32 | Host write data |
| regRdData | output | 32 | Read data, registered one cycle after the read strobe |
| cfgOutValid | output | 1 | Output stream word valid |
| cfgOutReady | input | 1 | Engine accepts output word |
| cfgOutData | output | 32 | Output stream word |
| cfgRdActive | output | 1 | Readback request towards the engine |
| cfgInValid | input | 1 | Input stream word valid |
| cfgInData | input | 32 | Input stream word |

## Verification
The assertions rely on a few properties of the inputs. The host issues at most one register access per cycle. The engine keeps to the valid/ready rule on the output stream. Input words only count while the readback request is high. The stimulus drives every host access and every engine signal on the falling edge, one access at a time. The engine model offers input words only while the request is up, except in the one test that deliberately injects words outside a readback. The output ready pattern is switched between held low, always high and alternating, so that back-pressure occurs while the output word is being held.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  localparam int OFS_GIE   = 32'h01C;
  localparam int OFS_ISR   = 32'h020;
  localparam int OFS_IER   = 32'h028;
  localparam int OFS_WF    = 32'h100;
  localparam int OFS_RF    = 32'h104;
  localparam int OFS_RSIZE = 32'h108;
  localparam int OFS_CTRL  = 32'h10C;
  localparam int OFS_STAT  = 32'h110;
  localparam int OFS_VAC   = 32'h114;
  localparam int OFS_OCC   = 32'h118;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_GIE, SEL_ISR, SEL_IER, SEL_RF,
    SEL_RSIZE, SEL_CTRL, SEL_STAT, SEL_VAC, SEL_OCC
  } rd_sel_e;

  typedef enum logic [1:0] {ST_IDLE, ST_FLUSH, ST_READ} state_e;

  typedef struct packed {
    logic    wfPush;
    logic    rfPop;
    logic    rfPush;
    logic    wrGie;
    logic    wrIsr;
    logic    wrIer;
    logic    wrRsize;
    logic    flushing;
    logic    readback;
    logic    eos;
    logic    rdEn;
    rd_sel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/cfgp_fifo.sv
module cfgp_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= wrData;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (doPop) rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2: occupancy never exceeds the storage depth
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R3: a push into a full FIFO without a pop leaves the count unchanged
  p_full_push_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> (count == $past(count)));

endmodule

// File: rtl/cfgp_control.sv
module cfgp_control
  import cfgp_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int RSIZE_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [1:0]         ctrlBits,
  input  logic [RSIZE_W-1:0] readSize,
  input  logic               wfEmpty,
  input  logic               cfgInValid,
  output strobe_t            strb
);
  state_e             state;
  logic [RSIZE_W-1:0] remaining;
  logic               eosReg;
  logic [31:0]        addrW;
  logic               ctrlHit;

  assign addrW   = 32'(regAddr);
  assign ctrlHit = regWrEn && (addrW == OFS_CTRL);

  always_comb begin
    strb          = '0;
    strb.wfPush   = regWrEn && (addrW == OFS_WF);
    strb.wrGie    = regWrEn && (addrW == OFS_GIE);
    strb.wrIsr    = regWrEn && (addrW == OFS_ISR);
    strb.wrIer    = regWrEn && (addrW == OFS_IER);
    strb.wrRsize  = regWrEn && (addrW == OFS_RSIZE);
    strb.rfPop    = regRdEn && (addrW == OFS_RF);
    strb.rfPush   = (state == ST_READ) && cfgInValid;
    strb.flushing = (state == ST_FLUSH);
    strb.readback = (state == ST_READ);
    strb.eos      = eosReg;
    strb.rdEn     = regRdEn;
    case (addrW)
      OFS_GIE:   strb.rdSel = SEL_GIE;
      OFS_ISR:   strb.rdSel = SEL_ISR;
      OFS_IER:   strb.rdSel = SEL_IER;
      OFS_RF:    strb.rdSel = SEL_RF;
      OFS_RSIZE: strb.rdSel = SEL_RSIZE;
      OFS_CTRL:  strb.rdSel = SEL_CTRL;
      OFS_STAT:  strb.rdSel = SEL_STAT;
      OFS_VAC:   strb.rdSel = SEL_VAC;
      OFS_OCC:   strb.rdSel = SEL_OCC;
      default:   strb.rdSel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
      eosReg    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ctrlHit && ctrlBits[0]) begin
            state <= ST_FLUSH;
          end else if (ctrlHit && ctrlBits[1] && (readSize != '0)) begin
            state     <= ST_READ;
            remaining <= readSize;
          end
        end
        ST_FLUSH: begin
          if (wfEmpty) begin
            state  <= ST_IDLE;
            eosReg <= 1'b1;
          end
        end
        ST_READ: begin
          if (cfgInValid) begin
            remaining <= remaining - 1'b1;
            if (remaining == RSIZE_W'(1)) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: a flush is never followed directly by a readback
  p_no_read_after_flush_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FLUSH) |=> (state != ST_READ));

  // R6: each accepted input word lowers the outstanding count by one
  p_remaining_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && cfgInValid && remaining > RSIZE_W'(1))
      |=> (remaining == $past(remaining) - 1'b1));

  // R5: end-of-startup never clears
  p_eos_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    eosReg |=> eosReg);

endmodule

// File: rtl/cfgp_datapath.sv
module cfgp_datapath
  import cfgp_pkg::*;
#(
  parameter int WF_DEPTH = 16,
  parameter int RF_DEPTH = 8,
  parameter int RSIZE_W  = 16,
  localparam int WF_CNT_W = $clog2(WF_DEPTH + 1),
  localparam int RF_CNT_W = $clog2(RF_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic [RSIZE_W-1:0] readSize,
  output logic               wfEmpty,
  output logic               cfgOutValid,
  input  logic               cfgOutReady,
  output logic [31:0]        cfgOutData,
  input  logic [31:0]        cfgInData
);
  logic [WF_CNT_W-1:0] wfCount;
  logic [RF_CNT_W-1:0] rfCount;
  logic                wfFull, rfFull, rfEmpty, wfPop;
  logic [31:0]         rfHead, rdMux;
  logic                gieBit, ovfFlag;
  logic [3:0]          ierBits;

  assign cfgOutValid = strb.flushing && !wfEmpty;
  assign wfPop       = cfgOutValid && cfgOutReady;

  cfgp_fifo #(.WIDTH(32), .DEPTH(WF_DEPTH)) i_wrFifo (
    .clk(clk), .rstN(rstN), .push(strb.wfPush), .pop(wfPop),
    .wrData(regWrData), .rdData(cfgOutData), .count(wfCount),
    .full(wfFull), .empty(wfEmpty)
  );

  cfgp_fifo #(.WIDTH(32), .DEPTH(RF_DEPTH)) i_rdFifo (
    .clk(clk), .rstN(rstN), .push(strb.rfPush), .pop(strb.rfPop),
    .wrData(cfgInData), .rdData(rfHead), .count(rfCount),
    .full(rfFull), .empty(rfEmpty)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gieBit   <= 1'b0;
      ierBits  <= '0;
      ovfFlag  <= 1'b0;
      readSize <= '0;
    end else begin
      if (strb.wrGie)   gieBit   <= regWrData[0];
      if (strb.wrIer)   ierBits  <= regWrData[3:0];
      if (strb.wrRsize) readSize <= regWrData[RSIZE_W-1:0];
      if (strb.wfPush && wfFull)              ovfFlag <= 1'b1;
      else if (strb.wrIsr && regWrData[0])    ovfFlag <= 1'b0;
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_GIE:   rdMux = {31'b0, gieBit};
      SEL_ISR:   rdMux = {31'b0, ovfFlag};
      SEL_IER:   rdMux = {28'b0, ierBits};
      SEL_RF:    rdMux = rfEmpty ? 32'b0 : rfHead;
      SEL_RSIZE: rdMux = 32'(readSize);
      SEL_CTRL:  rdMux = {30'b0, strb.readback, strb.flushing};
      SEL_STAT:  rdMux = {29'b0, strb.eos, 1'b0, !(strb.flushing || strb.readback)};
      SEL_VAC:   rdMux = 32'(WF_DEPTH) - 32'(wfCount);
      SEL_OCC:   rdMux = 32'(rfCount);
      default:   rdMux = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          regRdData <= '0;
    else if (strb.rdEn) regRdData <= rdMux;
  end

  // R3: overflow flag stays set unless cleared by a write of 1
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(strb.wrIsr && regWrData[0])) |=> ovfFlag);

  // R4: a stalled output word is held until accepted
  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOutValid && !cfgOutReady) |=> (cfgOutValid && $stable(cfgOutData)));

  // R4: a flush only finishes after the write FIFO has drained
  p_flush_drained_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.flushing) |-> $past(wfEmpty));

  // R12: the read FIFO never reports full and empty together
  p_rf_flags_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(rfFull && rfEmpty));

endmodule

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl
  import cfgp_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int WF_DEPTH = 16,
  parameter int RF_DEPTH = 8,
  parameter int RSIZE_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              cfgOutValid,
  input  logic              cfgOutReady,
  output logic [31:0]       cfgOutData,
  output logic              cfgRdActive,
  input  logic              cfgInValid,
  input  logic [31:0]       cfgInData
);
  strobe_t            strb;
  logic [RSIZE_W-1:0] readSize;
  logic               wfEmpty;

  assign cfgRdActive = strb.readback;

  cfgp_control #(.ADDR_W(ADDR_W), .RSIZE_W(RSIZE_W)) i_control (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .ctrlBits(regWrData[1:0]), .readSize(readSize),
    .wfEmpty(wfEmpty), .cfgInValid(cfgInValid), .strb(strb)
  );

  cfgp_datapath #(.WF_DEPTH(WF_DEPTH), .RF_DEPTH(RF_DEPTH), .RSIZE_W(RSIZE_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .regRdData(regRdData), .readSize(readSize), .wfEmpty(wfEmpty),
    .cfgOutValid(cfgOutValid), .cfgOutReady(cfgOutReady),
    .cfgOutData(cfgOutData), .cfgInData(cfgInData)
  );

endmodule

// File: tb/test_cfg_access_ctrl.sv
module test_cfg_access_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [12:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        cfgOutValid, cfgRdActive;
  logic        cfgOutReady = 1'b0;
  logic [31:0] cfgOutData;
  logic        cfgInValid = 1'b0;
  logic [31:0] cfgInData = '0;

  int passN = 0, totalN = 0;
  int readyMode = 0;
  bit readyTog = 0;
  bit srcEn = 0, forceIn = 0;
  int srcIdx = 0;
  logic [31:0] cap [64];
  int capN = 0;
  bit sawRdActive = 0;

  always #2.5 clk = ~clk;

  cfg_access_ctrl i_cfg_access_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .cfgOutValid(cfgOutValid), .cfgOutReady(cfgOutReady), .cfgOutData(cfgOutData),
    .cfgRdActive(cfgRdActive), .cfgInValid(cfgInValid), .cfgInData(cfgInData)
  );

  // engine model: output sink and input source, driven on the falling edge
  always @(negedge clk) begin
    readyTog    <= ~readyTog;
    cfgOutReady <= (readyMode == 1) || (readyMode == 2 && readyTog);
    if (forceIn) begin
      cfgInValid <= 1'b1;
      cfgInData  <= 32'hDEAD0000;
    end else if (srcEn && cfgRdActive) begin
      cfgInValid <= 1'b1;
      cfgInData  <= 32'hA000_0000 + 32'(srcIdx);
      srcIdx     <= srcIdx + 1;
    end else begin
      cfgInValid <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (cfgOutValid && cfgOutReady && capN < 64) begin
      cap[capN] <= cfgOutData;
      capN      <= capN + 1;
    end
    if (cfgRdActive) sawRdActive <= 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    totalN++;
    if (act === exp) passN++;
    else $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
  endtask

  task automatic busWrite(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    busRead(13'h110, d); chk("R1 status", d, 32'h1);
    busRead(13'h114, d); chk("R1 vacancy", d, 32'd16);
    busRead(13'h118, d); chk("R1 occupancy", d, 32'd0);
    busRead(13'h020, d); chk("R1 isr", d, 32'd0);
  endtask

  task automatic testFlush();
    logic [31:0] d;
    readyMode = 0; capN = 0;
    for (int i = 0; i < 3; i++) busWrite(13'h100, 32'hC0DE_0000 + 32'(i));
    busRead(13'h114, d); chk("R2 vacancy after 3", d, 32'd13);
    busWrite(13'h10C, 32'h1);
    busRead(13'h10C, d); chk("R4 ctrl busy", d, 32'h1);
    busRead(13'h110, d); chk("R4 status busy", d, 32'h0);
    chk("R4 nothing sent while stalled", 32'(capN), 32'd0);
    readyMode = 2;
    idle(20);
    chk("R4 words sent", 32'(capN), 32'd3);
    for (int i = 0; i < 3; i++) chk("R4 word order", cap[i], 32'hC0DE_0000 + 32'(i));
    busRead(13'h10C, d); chk("R4 ctrl cleared", d, 32'h0);
    busRead(13'h110, d); chk("R5 status done+eos", d, 32'h5);
    busRead(13'h114, d); chk("R4 vacancy restored", d, 32'd16);
  endtask

  task automatic testOverflow();
    logic [31:0] d;
    readyMode = 1; capN = 0;
    for (int i = 0; i < 17; i++) busWrite(13'h100, 32'h5000 + 32'(i));
    busRead(13'h114, d); chk("R3 vacancy zero", d, 32'd0);
    busRead(13'h020, d); chk("R3 overflow set", d, 32'h1);
    busWrite(13'h020, 32'h0);
    busRead(13'h020, d); chk("R3 overflow sticky", d, 32'h1);
    busWrite(13'h020, 32'h1);
    busRead(13'h020, d); chk("R3 overflow cleared", d, 32'h0);
    busWrite(13'h10C, 32'h1);
    idle(30);
    chk("R3 dropped word not sent", 32'(capN), 32'd16);
    chk("R3 last kept word", cap[15], 32'h500F);
  endtask

  task automatic testReadback();
    logic [31:0] d;
    srcEn = 1; srcIdx = 0;
    busWrite(13'h108, 32'd3);
    busRead(13'h108, d); chk("R6 size readback", d, 32'd3);
    busWrite(13'h10C, 32'h2);
    chk("R6 request raised", 32'(cfgRdActive), 32'd1);
    idle(10);
    chk("R6 request dropped", 32'(cfgRdActive), 32'd0);
    busRead(13'h118, d); chk("R6 occupancy", d, 32'd3);
    busRead(13'h110, d); chk("R6 done", d, 32'h5);
    for (int i = 0; i < 3; i++) begin
      busRead(13'h104, d); chk("R7 pop value", d, 32'hA000_0000 + 32'(i));
      busRead(13'h118, d); chk("R7 occupancy step", d, 32'(2 - i));
    end
    busRead(13'h104, d); chk("R7 empty pop", d, 32'd0);
    busRead(13'h118, d); chk("R7 empty occupancy", d, 32'd0);
  endtask

  task automatic testIgnoreIn();
    logic [31:0] d;
    forceIn = 1;
    idle(5);
    forceIn = 0;
    idle(2);
    busRead(13'h118, d); chk("R8 stray input ignored", d, 32'd0);
  endtask

  task automatic testBusy();
    logic [31:0] d;
    readyMode = 0; capN = 0; sawRdActive = 0;
    busWrite(13'h100, 32'h7001);
    busWrite(13'h100, 32'h7002);
    busWrite(13'h108, 32'd2);
    busWrite(13'h10C, 32'h1);
    busWrite(13'h10C, 32'h2);
    busRead(13'h10C, d); chk("R9 ctrl during flush", d, 32'h1);
    readyMode = 1;
    idle(10);
    chk("R9 no readback started", 32'(sawRdActive), 32'd0);
    busRead(13'h118, d); chk("R9 occupancy", d, 32'd0);
    chk("R9 flush words", 32'(capN), 32'd2);
    sawRdActive = 0;
    busWrite(13'h10C, 32'h3);
    idle(10);
    chk("R9 both bits flush only", 32'(sawRdActive), 32'd0);
    busRead(13'h110, d); chk("R9 idle after both", d, 32'h5);
  endtask

  task automatic testRegs();
    logic [31:0] d;
    busWrite(13'h01C, 32'h3);
    busRead(13'h01C, d); chk("R10 gie", d, 32'h1);
    busWrite(13'h028, 32'hFF);
    busRead(13'h028, d); chk("R10 ier", d, 32'hF);
    busRead(13'h024, d); chk("R10 unmapped", d, 32'h0);
    busRead(13'h1000, d); chk("R10 top address", d, 32'h0);
  endtask

  task automatic testZeroSize();
    logic [31:0] d;
    sawRdActive = 0;
    busWrite(13'h108, 32'd0);
    busWrite(13'h10C, 32'h2);
    idle(4);
    chk("R11 no request", 32'(sawRdActive), 32'd0);
    busRead(13'h110, d); chk("R11 done", d, 32'h5);
  endtask

  task automatic testRfFull();
    logic [31:0] d;
    srcIdx = 0;
    busWrite(13'h108, 32'd10);
    busWrite(13'h10C, 32'h2);
    idle(20);
    chk("R12 request ended", 32'(cfgRdActive), 32'd0);
    busRead(13'h118, d); chk("R12 occupancy capped", d, 32'd8);
    for (int i = 0; i < 8; i++) begin
      busRead(13'h104, d); chk("R12 kept words", d, 32'hA000_0000 + 32'(i));
    end
    busRead(13'h118, d); chk("R12 drained", d, 32'd0);
  endtask

  bit finished = 0;

  initial begin
    idle(4);
    rstN = 1'b1;
    idle(2);
    testReset();
    testFlush();
    testOverflow();
    testReadback();
    testIgnoreIn();
    testBusy();
    testRegs();
    testZeroSize();
    testRfFull();
    finished = 1;
    $display("%0d/%0d checks passed", passN, totalN);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      totalN++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", passN, totalN);
      $finish;
    end
  end

endmodule